// File: doc/BRIEF.md
# Host Bus Slave with User Completion Handshake

This block is a synchronous slave port that a host microprocessor reaches over a simple strobe bus, and everything in it is clocked by the host interface clock. The host opens an access by pulling an address strobe low. Two chip selects qualify the access: one is active low and one is active high. The host does not have to present the selects on the same edge as the strobe. The block watches for them over a short window of rising edges. As soon as it sees both valid, it remembers the selection, so the host may drop them.

Once the block has accepted an access, it stores the direction and write data. It then lowers an active-low start line toward user logic, and it changes that line only on falling clock edges. The access lasts as long as user logic needs. It ends only when user logic pulls an active-low end line, which the block samples on a rising edge. The block then drives a one-cycle active-low ready back to the host. On a read, the value captured from user logic appears on the host read bus in that same cycle. The user's level interrupt request goes straight through to the host.

Top module: `hostbus_user_slave`

## Requirements
- R1: During and just after reset, ready (`hs_rdy_n`) and start (`u_start_n`) are both high, and the read bus is released (`hs_rdata_oe` = 0, `hs_rdata` = 0).
- R2: Count the rising edge at which the strobe is first sampled low as edge 1. An access is accepted if both selects are valid (`hs_sel0_n` = 0 and `hs_sel1` = 1) at edge 1, 2 or 3 (SEL_WINDOW = 3).
- R3: If the selects are not both valid at any of those edges, including the case where they first become valid at edge 4, the access is dropped. Start stays high and ready is never given.
- R4: Once the selects have been recognised, the host may deassert them and the access still completes normally.
- R5: At the rising edge after recognition, the block samples direction (`hs_wr`, 1 = write) and write data. These appear on `u_wr` and `u_wdata` and stay there after ready, even if the host changes its inputs.
- R6: `u_start_n` changes only on falling clock edges. It goes low after an access is accepted and stays low through the ready cycle.
- R7: An access waits for `u_end_n` without any limit. Ready falls only at the rising edge that samples `u_end_n` low while start is low.
- R8: Ready is low for exactly one cycle, and it starts at the edge that samples the end. On a read, `hs_rdata_oe` is 1 in that cycle and `hs_rdata` carries `u_rdata` as sampled at that edge. On a write, `hs_rdata_oe` stays 0.
- R9: A strobe that arrives while an access is still open is ignored, so only one ready results.
- R10: `hs_irq_n` follows the user's level request `u_irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_strb_n | input | 1 | Host address strobe, active low |
| hs_sel0_n | input | 1 | Chip select, active low |
| hs_sel1 | input | 1 | Chip select, active high |
| hs_wr | input | 1 | Direction: 1 write, 0 read |
| hs_wdata | input | DW | Host write data |
| hs_rdata | output | DW | Read data to host, zero when released |
| hs_rdata_oe | output | 1 | Read bus drive enable |
| hs_rdy_n | output | 1 | Ready to host, active low, one cycle |
| hs_irq_n | output | 1 | Interrupt request to host, active low level |
| u_start_n | output | 1 | Access start to user logic, active low, falling-edge launched |
| u_end_n | input | 1 | Access end from user logic, active low |
| u_rdata | input | DW | Read data from user logic |
| u_wdata | output | DW | Latched write data to user logic |
| u_wr | output | 1 | Latched direction to user logic |
| u_irq_n | input | 1 | User interrupt request, active low level |

## Verification
The hardest situation to reach from the ports is a second strobe that lands while an access is open and user logic is still holding the end line off. To create it, the bench forks two processes. One runs a normal access with a long end delay. The other fires a fully qualified strobe a few cycles later, and the bench then requires that exactly one ready results. The window boundary is also tested: selects presented first at edge 3 must be accepted, and selects presented first at edge 4 must be dropped.

// File: rtl/hostbus_user_slave.sv
module hostbus_user_slave #(
  parameter int DW         = 8,
  parameter int SEL_WINDOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_strb_n,
  input  logic          hs_sel0_n,
  input  logic          hs_sel1,
  input  logic          hs_wr,
  input  logic [DW-1:0] hs_wdata,
  output logic [DW-1:0] hs_rdata,
  output logic          hs_rdata_oe,
  output logic          hs_rdy_n,
  output logic          hs_irq_n,
  output logic          u_start_n,
  input  logic          u_end_n,
  input  logic [DW-1:0] u_rdata,
  output logic [DW-1:0] u_wdata,
  output logic          u_wr,
  input  logic          u_irq_n
);

  localparam int CW = $clog2(SEL_WINDOW + 1);

  typedef enum logic [2:0] {S_IDLE, S_WIN, S_CAPT, S_WAIT, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] edge_cnt;
  logic          start_req;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rd_q;

  wire sel_ok = !hs_sel0_n && hs_sel1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      edge_cnt  <= '0;
      start_req <= 1'b0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      rd_q      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!hs_strb_n) begin
            if (sel_ok) begin
              st <= S_CAPT;
            end else if (SEL_WINDOW > 1) begin
              st       <= S_WIN;
              edge_cnt <= CW'(1);
            end
          end
        end
        S_WIN: begin
          if (sel_ok)
            st <= S_CAPT;
          else if (edge_cnt == CW'(SEL_WINDOW - 1))
            st <= S_IDLE;
          else
            edge_cnt <= edge_cnt + CW'(1);
        end
        S_CAPT: begin
          wr_q      <= hs_wr;
          wd_q      <= hs_wdata;
          start_req <= 1'b1;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (!u_start_n && !u_end_n) begin
            rd_q <= u_rdata;
            st   <= S_DONE;
          end
        end
        S_DONE: begin
          start_req <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) u_start_n <= 1'b1;
    else        u_start_n <= !start_req;
  end

  assign hs_rdy_n    = (st != S_DONE);
  assign hs_rdata_oe = (st == S_DONE) && !wr_q;
  assign hs_rdata    = hs_rdata_oe ? rd_q : '0;
  assign u_wdata     = wd_q;
  assign u_wr        = wr_q;
  assign hs_irq_n    = u_irq_n;

  assert_rdy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_rdy_n |=> hs_rdy_n);

  assert_rdy_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_rdy_n) |-> $past(!u_end_n));

  assert_start_through_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_rdy_n |-> !u_start_n);

  assert_oe_in_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rdata_oe |-> !hs_rdy_n);

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN) |-> (int'(edge_cnt) < SEL_WINDOW));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |=> (st == S_WAIT) || (st == S_DONE));

endmodule

// File: tb/tb_hostbus_user_slave.sv
`timescale 1ns/100ps
module tb_hostbus_user_slave;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hs_strb_n, hs_sel0_n, hs_sel1, hs_wr;
  logic [7:0] hs_wdata, hs_rdata, u_rdata, u_wdata;
  logic       hs_rdata_oe, hs_rdy_n, hs_irq_n, u_start_n, u_end_n, u_wr, u_irq_n;

  hostbus_user_slave dut (
    .clk(clk), .rst_n(rst_n), .hs_strb_n(hs_strb_n), .hs_sel0_n(hs_sel0_n),
    .hs_sel1(hs_sel1), .hs_wr(hs_wr), .hs_wdata(hs_wdata), .hs_rdata(hs_rdata),
    .hs_rdata_oe(hs_rdata_oe), .hs_rdy_n(hs_rdy_n), .hs_irq_n(hs_irq_n),
    .u_start_n(u_start_n), .u_end_n(u_end_n), .u_rdata(u_rdata),
    .u_wdata(u_wdata), .u_wr(u_wr), .u_irq_n(u_irq_n));

  always #2 clk = ~clk;

  typedef struct {bit wr; logic [7:0] d; string tag;} item_t;
  item_t exp_q[$];

  int checks = 0, fails = 0, cyc = 0, end_cyc = -10, rdy_cnt = 0;
  int end_delay = 0, bad_edge = 0;
  logic [7:0] rd_val = 8'h00;
  logic st_neg = 1'b1;
  bit prev_low = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // R6: start must not move at rising edges
  always @(posedge clk) begin
    #1;
    if (rst_n && u_start_n !== st_neg) bad_edge++;
  end

  // monitor: ready timing and scoreboard compare
  initial begin
    forever begin
      step();
      st_neg = u_start_n;
      if (prev_low) chk(hs_rdy_n === 1'b1, "R8 ready one cycle", hs_rdy_n, 1);
      if (rst_n && !hs_rdy_n) begin
        item_t it;
        chk(cyc == end_cyc + 1, "R7 ready at end edge", cyc, end_cyc + 1);
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected ready", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk(u_wr === it.wr, {it.tag, " R5 direction"}, u_wr, it.wr);
          if (it.wr) begin
            chk(u_wdata === it.d, {it.tag, " R5 write data"}, u_wdata, it.d);
            chk(hs_rdata_oe === 1'b0, {it.tag, " R8 no drive on write"}, hs_rdata_oe, 0);
          end else begin
            chk(hs_rdata_oe === 1'b1 && hs_rdata === it.d, {it.tag, " R8 read data"},
                hs_rdata, it.d);
          end
        end
        rdy_cnt++;
      end
      prev_low = rst_n && !hs_rdy_n;
    end
  end

  // user logic model
  initial begin
    u_end_n = 1'b1;
    u_rdata = 8'h00;
    forever begin
      do step(); while (u_start_n !== 1'b0);
      repeat (end_delay) step();
      u_end_n = 1'b0;
      u_rdata = rd_val;
      end_cyc = cyc;
      do step(); while (u_start_n !== 1'b1);
      u_end_n = 1'b1;
      u_rdata = 8'h00;
    end
  end

  task automatic do_access(input int sel_edge, input bit wr, input logic [7:0] wd,
                           input logic [7:0] rd, input int dly, input string tag);
    int c0;
    bit saw_start;
    c0 = rdy_cnt;
    saw_start = 0;
    end_delay = dly;
    rd_val = rd;
    hs_wr = wr;
    hs_wdata = wd;
    for (int k = 1; k <= 4; k++) begin
      hs_strb_n = (k == 1) ? 1'b0 : 1'b1;
      hs_sel0_n = (k == sel_edge) ? 1'b0 : 1'b1;
      hs_sel1   = (k == sel_edge) ? 1'b1 : 1'b0;
      if (k == 1 && sel_edge >= 1 && sel_edge <= 3) exp_q.push_back('{wr, wr ? wd : rd, tag});
      step();
      if (!u_start_n) saw_start = 1;
    end
    hs_sel0_n = 1'b1;
    hs_sel1 = 1'b0;
    if (sel_edge >= 1 && sel_edge <= 3) begin
      while (rdy_cnt == c0) step();
      hs_wdata = ~wd;
      hs_wr = ~wr;
      step();
      chk(u_wdata === wd && u_wr === wr, "R5 latched after host change", u_wdata, wd);
      step();
    end else begin
      repeat (4) begin
        step();
        if (!u_start_n) saw_start = 1;
      end
      chk(!saw_start && rdy_cnt == c0, "R3 dropped access", saw_start, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hs_strb_n = 1'b1; hs_sel0_n = 1'b1; hs_sel1 = 1'b0;
    hs_wr = 1'b0; hs_wdata = 8'h00; u_irq_n = 1'b1;
    repeat (3) step();
    chk(hs_rdy_n === 1'b1 && u_start_n === 1'b1, "R1 reset outputs", {hs_rdy_n, u_start_n}, 3);
    chk(hs_rdata_oe === 1'b0 && hs_rdata === 8'h00, "R1 bus released", hs_rdata_oe, 0);
    rst_n = 1'b1;
    repeat (2) step();
    chk(hs_rdy_n === 1'b1 && u_start_n === 1'b1, "R1 after reset", {hs_rdy_n, u_start_n}, 3);

    u_irq_n = 1'b0; #1;
    chk(hs_irq_n === 1'b0, "R10 irq low", hs_irq_n, 0);
    step();
    u_irq_n = 1'b1; #1;
    chk(hs_irq_n === 1'b1, "R10 irq high", hs_irq_n, 1);
    step();

    do_access(1, 1'b1, 8'hA5, 8'h00, 0, "R2 R4 edge1 write");
    do_access(2, 1'b0, 8'h00, 8'h3C, 2, "R2 edge2 read");
    do_access(3, 1'b1, 8'h5A, 8'h00, 1, "R2 edge3 write");
    do_access(1, 1'b0, 8'h00, 8'hC3, 40, "R7 long wait read");
    do_access(3, 1'b0, 8'h00, 8'hFF, 0, "R2 edge3 read");
    do_access(0, 1'b1, 8'h11, 8'h00, 0, "R3 no select");
    do_access(4, 1'b1, 8'h22, 8'h00, 0, "R3 select too late");
    do_access(2, 1'b1, 8'h00, 8'h00, 3, "R2 write zero");

    begin
      int c0;
      c0 = rdy_cnt;
      fork
        do_access(1, 1'b1, 8'h77, 8'h00, 12, "R9 busy write");
        begin
          repeat (6) step();
          hs_strb_n = 1'b0; hs_sel0_n = 1'b0; hs_sel1 = 1'b1;
          step();
          hs_strb_n = 1'b1; hs_sel0_n = 1'b1; hs_sel1 = 1'b0;
        end
      join
      repeat (8) step();
      chk(rdy_cnt == c0 + 1 && exp_q.size() == 0, "R9 one ready only", rdy_cnt - c0, 1);
    end

    chk(bad_edge == 0, "R6 start moves on falling edge only", bad_edge, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule